// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block runs the fixed seven-cycle bus sequence that a small 8-bit processor core uses to enter a handler after a power-up reset, a non-maskable interrupt or a maskable interrupt request. The core's control logic decides that an entry is due. It then pulses `start_i` and presents the entry kind together with the current program counter, stack pointer and status byte. The sequencer takes over the memory bus for seven cycles. It makes two throwaway reads at the program counter. It then saves the return state on the stack, or for a reset only touches those stack addresses with reads. Finally it fetches a two-byte handler address from a fixed location that depends on the entry kind.

When the sequence ends, the block presents the new program counter, the stack pointer lowered by three and the updated status byte, and raises `done_o` for one cycle. A parameter picks the flag rule. In one variant the decimal-mode flag is left as it is. In the other variant that flag is cleared on entry. Both variants set the interrupt mask flag.

Top module: `irq_entry_seq`

## Requirements
- R1: After an accepted `start_i`, `busy_o` is high for exactly seven cycles. `done_o` rises in the cycle right after the seventh bus cycle.
- R2: Bus cycles 1 and 2 are reads (`bus_rd_o`=1, `bus_wr_o`=0) at the program counter given with `start_i`.
- R3: For kind 1 (NMI) and kind 2 or 3 (IRQ), cycles 3, 4 and 5 are writes. Cycle 3 writes the PC high byte to address {page, SP}. Cycle 4 writes the PC low byte to {page, SP-1}. Cycle 5 writes the status byte to {page, SP-2}.
- R4: For kind 0 (reset), cycles 3 to 5 are reads at the same three stack addresses, with no write. `sp_o` still ends at SP-3.
- R5: The low byte of a stack address wraps within 8 bits. The high byte is always the parameter STACK_PAGE (default 0x01).
- R6: Cycles 6 and 7 read the handler address low byte and then the high byte. The locations are 0xFFFA/0xFFFB for NMI, 0xFFFC/0xFFFD for reset and 0xFFFE/0xFFFF for IRQ.
- R7: The pushed status byte always has bit 4 at 0. All other bits are copied from `status_i`.
- R8: On completion, `status_o` has bit 2 (interrupt mask) set. Bit 3 (decimal) is cleared when CMOS_VARIANT=1 and is left unchanged when CMOS_VARIANT=0. The other bits follow `status_i`.
- R9: On completion, `pc_o` = {byte read in cycle 7, byte read in cycle 6}. `done_o` is high for one cycle only.
- R10: A `start_i` that arrives while a sequence is running is ignored. The running sequence keeps its kind, addresses and result, and no new sequence follows.
- R11: A synchronous reset (`rst`) returns the block to idle, with `busy_o`, `done_o`, `bus_rd_o` and `bus_wr_o` all low.
- R12: While busy, every cycle asserts exactly one of `bus_rd_o` and `bus_wr_o`. `bus_wr_o` is asserted only in cycles 3 to 5 of an NMI or IRQ entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse to begin an entry sequence |
| kind_i | input | 2 | Entry kind: 0 reset, 1 NMI, 2 or 3 IRQ |
| pc_i | input | 16 | Program counter at entry |
| sp_i | input | 8 | Stack pointer at entry |
| status_i | input | 8 | Status byte at entry |
| bus_addr_o | output | 16 | Bus address |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, sampled at the end of the cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | New program counter |
| sp_o | output | 8 | New stack pointer |
| status_o | output | 8 | New status byte |

## Verification
The hardest cases to reach are a second `start_i` that lands in the middle of a running sequence and a reset that cuts a sequence short. The bench drives both. It raises `start_i` with a different kind and program counter during the third bus cycle, then checks that the addresses, handler fetch and result all still belong to the first request. In a separate run it asserts `rst` during the fourth cycle. Stack wrap is reached by starting with SP at 0x01, so the push addresses cross from 0x0100 to 0x01FF.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] FLAG_MASK_I = 8'h04;
    localparam logic [DATA_W-1:0] FLAG_DEC    = 8'h08;
    localparam logic [DATA_W-1:0] FLAG_BRKBIT = 8'h10;

    typedef enum logic [1:0] {
        KIND_RESET   = 2'd0,
        KIND_NMI     = 2'd1,
        KIND_IRQ     = 2'd2,
        KIND_IRQ_ALT = 2'd3
    } entry_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_DUMMY0  = 3'd1,
        PH_DUMMY1  = 3'd2,
        PH_SAVE_HI = 3'd3,
        PH_SAVE_LO = 3'd4,
        PH_SAVE_ST = 3'd5,
        PH_VEC_LO  = 3'd6,
        PH_VEC_HI  = 3'd7
    } phase_e;

    typedef struct packed {
        entry_kind_e         kind;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   st;
    } entry_ctx_t;

    function automatic logic [ADDR_W-1:0] vector_base(entry_kind_e k);
        case (k)
            KIND_NMI:   return 16'hFFFA;
            KIND_RESET: return 16'hFFFC;
            default:    return 16'hFFFE;
        endcase
    endfunction

    function automatic logic saves_state(entry_kind_e k);
        return k != KIND_RESET;
    endfunction

    function automatic logic is_stack_phase(phase_e p);
        return (p == PH_SAVE_HI) || (p == PH_SAVE_LO) || (p == PH_SAVE_ST);
    endfunction

endpackage

// File: rtl/irq_seq_phase.sv
module irq_seq_phase
    import irq_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    output phase_e phase_o,
    output logic   accept_o,
    output logic   last_o
);
    phase_e phase_q;

    assign accept_o = (phase_q == PH_IDLE) && start_i;
    assign last_o   = (phase_q == PH_VEC_HI);
    assign phase_o  = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (accept_o) begin
            phase_q <= PH_DUMMY0;
        end else if (last_o) begin
            phase_q <= PH_IDLE;
        end else if (phase_q != PH_IDLE) begin
            phase_q <= phase_e'(phase_q + 3'd1);
        end
    end

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> (phase_q != $past(phase_q))) else $error("phase stalled"); // R1

endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
    import irq_seq_pkg::*;
#(
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
)(
    input  phase_e              phase_i,
    input  entry_ctx_t          ctx_i,
    input  logic [DATA_W-1:0]   sp_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                rd_o,
    output logic                wr_o,
    output logic [DATA_W-1:0]   wdata_o
);
    logic [ADDR_W-1:0] vec;
    logic              push;

    assign vec  = vector_base(ctx_i.kind);
    assign push = saves_state(ctx_i.kind);

    always_comb begin
        addr_o  = '0;
        rd_o    = 1'b0;
        wr_o    = 1'b0;
        wdata_o = '0;
        case (phase_i)
            PH_DUMMY0, PH_DUMMY1: begin
                addr_o = ctx_i.pc;
                rd_o   = 1'b1;
            end
            PH_SAVE_HI, PH_SAVE_LO, PH_SAVE_ST: begin
                addr_o = {STACK_PAGE, sp_i};
                wr_o   = push;
                rd_o   = !push;
                if (push) begin
                    if (phase_i == PH_SAVE_HI)
                        wdata_o = ctx_i.pc[ADDR_W-1:DATA_W];
                    else if (phase_i == PH_SAVE_LO)
                        wdata_o = ctx_i.pc[DATA_W-1:0];
                    else
                        wdata_o = ctx_i.st & ~FLAG_BRKBIT;
                end
            end
            PH_VEC_LO: begin
                addr_o = vec;
                rd_o   = 1'b1;
            end
            PH_VEC_HI: begin
                addr_o = vec | 16'h0001;
                rd_o   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter bit                CMOS_VARIANT = 1'b0,
    parameter logic [DATA_W-1:0] STACK_PAGE   = 8'h01
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        kind_i,
    input  logic [15:0]       pc_i,
    input  logic [7:0]        sp_i,
    input  logic [7:0]        status_i,
    output logic [15:0]       bus_addr_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [7:0]        bus_wdata_o,
    input  logic [7:0]        bus_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       pc_o,
    output logic [7:0]        sp_o,
    output logic [7:0]        status_o
);
    phase_e            phase;
    logic              accept;
    logic              last;
    entry_ctx_t        ctx_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] vec_lo_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] st_q;
    logic              done_q;
    logic [DATA_W-1:0] st_final;

    irq_seq_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .phase_o  (phase),
        .accept_o (accept),
        .last_o   (last)
    );

    irq_seq_bus #(.STACK_PAGE(STACK_PAGE)) u_bus (
        .phase_i (phase),
        .ctx_i   (ctx_q),
        .sp_i    (sp_q),
        .addr_o  (bus_addr_o),
        .rd_o    (bus_rd_o),
        .wr_o    (bus_wr_o),
        .wdata_o (bus_wdata_o)
    );

    generate
        if (CMOS_VARIANT) begin : g_clear_dec
            assign st_final = (ctx_q.st | FLAG_MASK_I) & ~FLAG_DEC;
        end else begin : g_keep_dec
            assign st_final = ctx_q.st | FLAG_MASK_I;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q    <= '0;
            sp_q     <= '0;
            vec_lo_q <= '0;
            pc_q     <= '0;
            st_q     <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                ctx_q <= '{kind: entry_kind_e'(kind_i), pc: pc_i, st: status_i};
                sp_q  <= sp_i;
            end
            if (is_stack_phase(phase)) begin
                sp_q <= sp_q - 8'd1;
            end
            if (phase == PH_VEC_LO) begin
                vec_lo_q <= bus_rdata_i;
            end
            if (last) begin
                pc_q   <= {bus_rdata_i, vec_lo_q};
                st_q   <= st_final;
                done_q <= 1'b1;
            end
        end
    end

    assign busy_o   = (phase != PH_IDLE);
    assign done_o   = done_q;
    assign pc_o     = pc_q;
    assign sp_o     = sp_q;
    assign status_o = st_q;

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd_o && bus_wr_o)) else $error("rd and wr together"); // R12
    AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (bus_rd_o || bus_wr_o)) else $error("busy cycle without strobe"); // R12
    AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && ctx_q.kind == KIND_RESET) |-> !bus_wr_o) else $error("reset entry wrote"); // R4
    AST_STACK_PAGE: assert property (@(posedge clk) disable iff (rst)
        bus_wr_o |-> (bus_addr_o[15:8] == STACK_PAGE)) else $error("write outside stack page"); // R5
    AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
        is_stack_phase(phase) |=> (sp_q == $past(sp_q) - 8'd1)) else $error("sp step"); // R3
    AST_STATUS_B_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_o && phase == PH_SAVE_ST) |-> !bus_wdata_o[4]) else $error("pushed bit 4 set"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o) else $error("done held"); // R9
    AST_DONE_AFTER_VEC: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(phase) == PH_VEC_HI)) else $error("done out of order"); // R1
    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> status_o[2]) else $error("mask flag not set"); // R8

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0;
    logic [7:0]  st_in = '0;

    logic [15:0] n_addr, c_addr, n_pc, c_pc;
    logic        n_rd, n_wr, c_rd, c_wr, n_busy, c_busy, n_done, c_done;
    logic [7:0]  n_wdata, c_wdata, n_rdata, c_rdata, n_sp, c_sp, n_st, c_st;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign n_rdata = mem_byte(n_addr);
    assign c_rdata = mem_byte(c_addr);

    irq_entry_seq #(.CMOS_VARIANT(1'b0)) u_irq_entry_seq (
        .clk(clk), .rst(rst), .start_i(start), .kind_i(kind), .pc_i(pc_in),
        .sp_i(sp_in), .status_i(st_in), .bus_addr_o(n_addr), .bus_rd_o(n_rd),
        .bus_wr_o(n_wr), .bus_wdata_o(n_wdata), .bus_rdata_i(n_rdata),
        .busy_o(n_busy), .done_o(n_done), .pc_o(n_pc), .sp_o(n_sp), .status_o(n_st));

    irq_entry_seq #(.CMOS_VARIANT(1'b1)) u_cmos (
        .clk(clk), .rst(rst), .start_i(start), .kind_i(kind), .pc_i(pc_in),
        .sp_i(sp_in), .status_i(st_in), .bus_addr_o(c_addr), .bus_rd_o(c_rd),
        .bus_wr_o(c_wr), .bus_wdata_o(c_wdata), .bus_rdata_i(c_rdata),
        .busy_o(c_busy), .done_o(c_done), .pc_o(c_pc), .sp_o(c_sp), .status_o(c_st));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run_seq(input logic [1:0] k, input logic [15:0] pc, input logic [7:0] sp,
                           input logic [7:0] st, input int intrude);
        logic [15:0] vec;
        logic [7:0]  exp_addr_lo;
        bit          push;
        push = (k != 2'd0);
        vec  = (k == 2'd1) ? 16'hFFFA : (k == 2'd0) ? 16'hFFFC : 16'hFFFE;
        start = 1'b1; kind = k; pc_in = pc; sp_in = sp; st_in = st;
        @(negedge clk);
        start = 1'b0;
        for (int s = 1; s <= 7; s++) begin
            chk(n_busy, "R1", "busy during step", {31'd0, n_busy}, 32'd1);
            if (s <= 2) begin
                chk(n_addr == pc && n_rd && !n_wr, "R2", "dummy read addr", n_addr, pc);
            end else if (s <= 5) begin
                exp_addr_lo = sp - 8'(s - 3);
                chk(n_addr == {8'h01, exp_addr_lo}, "R5", "stack addr", n_addr, {8'h01, exp_addr_lo});
                if (push) begin
                    chk(n_wr && !n_rd, "R12", "stack write strobe", {n_rd, n_wr}, 32'd1);
                    if (s == 3) chk(n_wdata == pc[15:8], "R3", "push pc hi", n_wdata, pc[15:8]);
                    if (s == 4) chk(n_wdata == pc[7:0], "R3", "push pc lo", n_wdata, pc[7:0]);
                    if (s == 5) chk(n_wdata == (st & 8'hEF), "R7", "push status", n_wdata, st & 8'hEF);
                end else begin
                    chk(n_rd && !n_wr, "R4", "reset stack read", {n_rd, n_wr}, 32'd2);
                end
            end else begin
                chk(n_addr == vec + 16'(s - 6) && n_rd && !n_wr, "R6", "vector addr",
                    n_addr, vec + 16'(s - 6));
            end
            if (s == intrude) begin
                start = 1'b1; kind = 2'd1; pc_in = 16'h1357; sp_in = 8'h42; st_in = 8'h00;
            end
            if (s == intrude + 1) start = 1'b0;
            @(negedge clk);
        end
        chk(n_done && !n_busy, "R1", "done after seven cycles", {n_done, n_busy}, 32'd2);
        chk(n_pc == {mem_byte(vec | 16'h1), mem_byte(vec)}, "R9", "pc loaded",
            n_pc, {mem_byte(vec | 16'h1), mem_byte(vec)});
        chk(n_sp == sp - 8'd3, "R4", "sp minus three", n_sp, sp - 8'd3);
        chk(n_st == (st | 8'h04), "R8", "nmos status", n_st, st | 8'h04);
        chk(c_st == ((st | 8'h04) & 8'hF7), "R8", "cmos status", c_st, (st | 8'h04) & 8'hF7);
        @(negedge clk);
        chk(!n_done, "R9", "done one cycle", {31'd0, n_done}, 32'd0);
        chk(!n_busy, "R10", "no follow-on sequence", {31'd0, n_busy}, 32'd0);
    endtask

    task automatic t_reset_state();
        chk(!n_busy && !n_done && !n_rd && !n_wr, "R11", "idle after reset",
            {n_busy, n_done, n_rd, n_wr}, 32'd0);
    endtask

    task automatic t_irq();      run_seq(2'd2, 16'hC0DE, 8'hFD, 8'hFF, 0); endtask
    task automatic t_irq_alt();  run_seq(2'd3, 16'h8001, 8'h80, 8'h3B, 0); endtask
    task automatic t_nmi();      run_seq(2'd1, 16'h4A21, 8'h10, 8'h18, 0); endtask
    task automatic t_reset_kind(); run_seq(2'd0, 16'hFD00, 8'h00, 8'h08, 0); endtask
    task automatic t_wrap();     run_seq(2'd2, 16'h2345, 8'h01, 8'h10, 0); endtask // R5
    task automatic t_ignore();   run_seq(2'd2, 16'h0F0F, 8'hF0, 8'hC3, 3); endtask // R10

    task automatic t_sync_reset();
        start = 1'b1; kind = 2'd2; pc_in = 16'h5555; sp_in = 8'hAA; st_in = 8'h00;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!n_busy && !n_done && !n_rd && !n_wr, "R11", "abort to idle",
            {n_busy, n_done, n_rd, n_wr}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!n_busy, "R11", "stays idle", {31'd0, n_busy}, 32'd0);
        run_seq(2'd1, 16'h7777, 8'h33, 8'h00, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_irq();
        t_irq_alt();
        t_nmi();
        t_reset_kind();
        t_wrap();
        t_ignore();
        t_sync_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule